// File: doc/BRIEF.md
# Renaming Reorder Buffer

This block tracks in-flight instructions for a single-issue out-of-order ALU core. Each cycle it can take one dispatched instruction, made of an opcode, two source register numbers and a destination register number. The instruction goes into a circular buffer slot. The slot index becomes the tag under which the destination register is renamed. A rename table records, for every architectural register, whether its current value sits in the architectural register file or is still owed by an in-flight entry.

Source operands are resolved at dispatch. An operand that is still outstanding waits on its tag and takes its value from the tagged result bus when the producer finishes. Once both operands of an entry are present, the issue logic hands the entry to an external ALU. The ALU later returns the result on the same bus, tagged with the slot index. Completed entries leave from the oldest end in program order and update the architectural register file. A flush input drops every in-flight entry at once and makes the rename table point back at the register file.

Top module: `rob_rename`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1 and `iss_valid` and `ret_valid` are 0. Architectural register i holds the value i.
- R2: Retirement takes at most one entry per cycle. It takes the oldest entry, and only when that entry's result has been captured in an earlier cycle and `flush` is low. `ret_tag` advances by one modulo NUM_ENT, starting from 0 after reset or flush. `ret_reg` and `ret_value` give the entry's destination and result, and they are written to the architectural register file.
- R3: Whenever a register is marked renamed, its tag names a live entry whose destination is that register. Retirement marks the register as held in the file only if its tag still equals the retiring slot. A later dispatch to the same register therefore keeps readers on the newer producer.
- R4: At dispatch each source operand takes its value from the first available of these, in order: the result bus in the same cycle when it carries the renamed tag; the renamed entry if it has completed; the architectural register file if the register is not renamed. Otherwise the operand waits on the tag.
- R5: A result with valid high writes its value into every waiting operand whose tag matches. It also marks the entry with that slot index complete. Both changes are visible from the next cycle on.
- R6: `disp_ready` is 0 exactly when NUM_ENT entries are in flight. A dispatch offered while `disp_ready` is 0 changes nothing.
- R7: With `flush` high, every in-flight entry is discarded, no retirement or issue happens, and a dispatch in the same cycle is ignored. From the next cycle on, every register reads from the architectural register file.
- R8: Issue selects the oldest live entry that has not yet issued and has both operands present, no earlier than the cycle after its dispatch. It presents opcode, operands and tag with `iss_valid` high. No entry issues twice, and at most one entry issues per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all in-flight entries |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OW | Opcode of dispatched instruction |
| disp_src1 | input | RW | First source register |
| disp_src2 | input | RW | Second source register |
| disp_dest | input | RW | Destination register |
| disp_ready | output | 1 | A free slot exists |
| res_valid | input | 1 | Result bus valid |
| res_tag | input | TW | Slot index of the producer |
| res_value | input | DW | Result value |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_op | output | OW | Opcode of issued entry |
| iss_tag | output | TW | Slot index of issued entry |
| iss_a | output | DW | First operand value |
| iss_b | output | DW | Second operand value |
| ret_valid | output | 1 | An entry retires this cycle |
| ret_tag | output | TW | Slot index of retiring entry |
| ret_reg | output | RW | Destination register written |
| ret_value | output | DW | Value written |

## Verification
The assertions assume a well-behaved ALU on the result bus. The bus carries only tags that were issued and have not yet reported, it carries each such tag exactly once, and it is idle during a flush. The bench holds a pending list of issued tags and broadcasts random members of it in random order, which keeps completion out of order. It empties that list on flush. Dispatch requests are offered even while the buffer is full, because the block must tolerate them.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {SRC_WAIT, SRC_RF, SRC_ROB, SRC_BUS} opnd_src_e;

  // Operand source at dispatch: bypass beats completed entry beats file.
  function automatic opnd_src_e pick_src(logic in_file, logic bus_hit, logic prod_done);
    if (!in_file && bus_hit)   return SRC_BUS;
    if (!in_file && prod_done) return SRC_ROB;
    if (in_file)               return SRC_RF;
    return SRC_WAIT;
  endfunction

  // Distance of slot idx from the oldest slot in a ring of n.
  function automatic int ring_age(int idx, int head, int n);
    return (idx - head + n) % n;
  endfunction
endpackage

// File: rtl/rob_rename_table.sv
module rob_rename_table #(
  parameter int NA = 8,
  parameter int TW = 3,
  localparam int RW = $clog2(NA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [RW-1:0]     rd_a1,
  input  logic [RW-1:0]     rd_a2,
  output logic              rd_ok1,
  output logic [TW-1:0]     rd_tag1,
  output logic              rd_ok2,
  output logic [TW-1:0]     rd_tag2,
  input  logic              map_we,
  input  logic [RW-1:0]     map_reg,
  input  logic [TW-1:0]     map_tag,
  input  logic              rel_we,
  input  logic [RW-1:0]     rel_reg,
  input  logic [TW-1:0]     rel_tag,
  output logic [NA-1:0]     ok_vec,
  output logic [NA*TW-1:0]  tag_flat
);
  logic [TW-1:0] tag_q [NA];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NA; r++) begin ok_vec[r] <= 1'b1; tag_q[r] <= '0; end
    end else if (flush) begin
      for (int r = 0; r < NA; r++) ok_vec[r] <= 1'b1;
    end else begin
      for (int r = 0; r < NA; r++) begin
        if (map_we && map_reg == RW'(r)) begin
          ok_vec[r] <= 1'b0;
          tag_q[r]  <= map_tag;
        end else if (rel_we && rel_reg == RW'(r) && tag_q[r] == rel_tag) begin
          ok_vec[r] <= 1'b1;
        end
      end
    end
  end

  assign rd_ok1  = ok_vec[rd_a1];
  assign rd_tag1 = tag_q[rd_a1];
  assign rd_ok2  = ok_vec[rd_a2];
  assign rd_tag2 = tag_q[rd_a2];

  generate
    for (genvar r = 0; r < NA; r++) begin : g_flat
      assign tag_flat[r*TW +: TW] = tag_q[r];
    end
  endgenerate
endmodule

// File: rtl/rob_arch_rf.sv
module rob_arch_rf #(
  parameter int NA = 8,
  parameter int DW = 16,
  localparam int RW = $clog2(NA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [RW-1:0] ra1,
  input  logic [RW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  logic [DW-1:0] regs [NA];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NA; r++) regs[r] <= DW'(r);
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int NE = 8,
  parameter int RW = 3,
  parameter int DW = 16,
  parameter int OW = 2,
  localparam int TW = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          alloc_we,
  input  logic [TW-1:0] alloc_idx,
  input  logic [OW-1:0] alloc_op,
  input  logic [RW-1:0] alloc_dest,
  input  logic          a1_ok,
  input  logic [DW-1:0] a1_val,
  input  logic [TW-1:0] a1_tag,
  input  logic          a2_ok,
  input  logic [DW-1:0] a2_val,
  input  logic [TW-1:0] a2_tag,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic [DW-1:0] res_value,
  input  logic          iss_we,
  input  logic [TW-1:0] iss_idx,
  input  logic          ret_we,
  input  logic [TW-1:0] ret_idx,
  output logic [NE-1:0] busy,
  output logic [NE-1:0] done,
  output logic [NE-1:0] issued,
  output logic [NE-1:0] ok1,
  output logic [NE-1:0] ok2,
  output logic [OW-1:0] op    [NE],
  output logic [RW-1:0] dest  [NE],
  output logic [DW-1:0] value [NE],
  output logic [DW-1:0] v1    [NE],
  output logic [DW-1:0] v2    [NE]
);
  logic [TW-1:0] t1 [NE];
  logic [TW-1:0] t2 [NE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        busy[i] <= 1'b0; done[i] <= 1'b0; issued[i] <= 1'b0;
        ok1[i] <= 1'b0; ok2[i] <= 1'b0;
        op[i] <= '0; dest[i] <= '0; value[i] <= '0;
        v1[i] <= '0; v2[i] <= '0; t1[i] <= '0; t2[i] <= '0;
      end
    end else if (flush) begin
      for (int i = 0; i < NE; i++) begin
        busy[i] <= 1'b0; done[i] <= 1'b0; issued[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NE; i++) begin
        if (alloc_we && alloc_idx == TW'(i)) begin
          busy[i] <= 1'b1; done[i] <= 1'b0; issued[i] <= 1'b0;
          op[i] <= alloc_op; dest[i] <= alloc_dest;
          ok1[i] <= a1_ok; v1[i] <= a1_val; t1[i] <= a1_tag;
          ok2[i] <= a2_ok; v2[i] <= a2_val; t2[i] <= a2_tag;
        end else if (busy[i]) begin
          if (ret_we && ret_idx == TW'(i)) busy[i] <= 1'b0;
          if (res_valid && res_tag == TW'(i)) begin
            value[i] <= res_value;
            done[i]  <= 1'b1;
          end
          if (!ok1[i] && res_valid && res_tag == t1[i]) begin
            v1[i] <= res_value; ok1[i] <= 1'b1;
          end
          if (!ok2[i] && res_valid && res_tag == t2[i]) begin
            v2[i] <= res_value; ok2[i] <= 1'b1;
          end
          if (iss_we && iss_idx == TW'(i)) issued[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rob_issue_pick.sv
module rob_issue_pick #(
  parameter int NE = 8,
  localparam int TW = $clog2(NE)
) (
  input  logic [TW-1:0] head,
  input  logic [NE-1:0] cand,
  output logic          found,
  output logic [TW-1:0] pick
);
  // Scan from the oldest slot; NE must be a power of two so the index wraps.
  always_comb begin
    logic [TW-1:0] j;
    found = 1'b0;
    pick  = head;
    for (int k = 0; k < NE; k++) begin
      j = head + TW'(k);
      if (!found && cand[j]) begin
        found = 1'b1;
        pick  = j;
      end
    end
  end
endmodule

// File: rtl/rob_rename.sv
module rob_rename
  import rob_pkg::*;
#(
  parameter int NUM_ENT  = 8,
  parameter int NUM_ARCH = 8,
  parameter int DW       = 16,
  parameter int OW       = 2,
  localparam int TW = $clog2(NUM_ENT),
  localparam int RW = $clog2(NUM_ARCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          disp_valid,
  input  logic [OW-1:0] disp_op,
  input  logic [RW-1:0] disp_src1,
  input  logic [RW-1:0] disp_src2,
  input  logic [RW-1:0] disp_dest,
  output logic          disp_ready,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic [DW-1:0] res_value,
  output logic          iss_valid,
  output logic [OW-1:0] iss_op,
  output logic [TW-1:0] iss_tag,
  output logic [DW-1:0] iss_a,
  output logic [DW-1:0] iss_b,
  output logic          ret_valid,
  output logic [TW-1:0] ret_tag,
  output logic [RW-1:0] ret_reg,
  output logic [DW-1:0] ret_value
);
  logic [TW:0]   head_q, tail_q, occ;
  logic [TW-1:0] hidx, tidx;
  logic          full, empty, disp_fire, ret_fire;

  assign hidx  = head_q[TW-1:0];
  assign tidx  = tail_q[TW-1:0];
  assign occ   = tail_q - head_q;
  assign full  = (occ == (TW+1)'(NUM_ENT));
  assign empty = (occ == '0);

  // Entry storage
  logic [NUM_ENT-1:0] busy, done, issued, ok1, ok2;
  logic [OW-1:0] e_op   [NUM_ENT];
  logic [RW-1:0] e_dest [NUM_ENT];
  logic [DW-1:0] e_val  [NUM_ENT];
  logic [DW-1:0] e_v1   [NUM_ENT];
  logic [DW-1:0] e_v2   [NUM_ENT];

  // Rename lookup and file read for both sources
  logic          rn_ok1, rn_ok2;
  logic [TW-1:0] rn_tag1, rn_tag2;
  logic [DW-1:0] rf1, rf2;
  logic [NUM_ARCH-1:0]    ren_ok_vec;
  logic [NUM_ARCH*TW-1:0] ren_tag_flat;

  // Resolved operands
  opnd_src_e     src1_sel, src2_sel;
  logic          op1_ok, op2_ok;
  logic [DW-1:0] op1_val, op2_val;

  // Issue selection
  logic [NUM_ENT-1:0] cand;
  logic               pick_found;
  logic [TW-1:0]      pick_idx;

  // Named events for the checker
  logic [NUM_ENT-1:0]    live_vec;
  logic [NUM_ENT*RW-1:0] dest_flat;

  assign disp_ready = !full;
  assign disp_fire  = disp_valid && !full && !flush;
  assign ret_fire   = !empty && done[hidx] && !flush;

  always_comb begin
    src1_sel = pick_src(rn_ok1, res_valid && res_tag == rn_tag1, done[rn_tag1]);
    src2_sel = pick_src(rn_ok2, res_valid && res_tag == rn_tag2, done[rn_tag2]);
    op1_ok = (src1_sel != SRC_WAIT);
    op2_ok = (src2_sel != SRC_WAIT);
    case (src1_sel)
      SRC_BUS: op1_val = res_value;
      SRC_ROB: op1_val = e_val[rn_tag1];
      SRC_RF:  op1_val = rf1;
      default: op1_val = '0;
    endcase
    case (src2_sel)
      SRC_BUS: op2_val = res_value;
      SRC_ROB: op2_val = e_val[rn_tag2];
      SRC_RF:  op2_val = rf2;
      default: op2_val = '0;
    endcase
  end

  assign cand = busy & ~done & ~issued & ok1 & ok2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (ret_fire)  head_q <= head_q + 1'b1;
      if (disp_fire) tail_q <= tail_q + 1'b1;
    end
  end

  rob_rename_table #(.NA(NUM_ARCH), .TW(TW)) u_ren (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd_a1(disp_src1), .rd_a2(disp_src2),
    .rd_ok1(rn_ok1), .rd_tag1(rn_tag1), .rd_ok2(rn_ok2), .rd_tag2(rn_tag2),
    .map_we(disp_fire), .map_reg(disp_dest), .map_tag(tidx),
    .rel_we(ret_fire), .rel_reg(e_dest[hidx]), .rel_tag(hidx),
    .ok_vec(ren_ok_vec), .tag_flat(ren_tag_flat)
  );

  rob_arch_rf #(.NA(NUM_ARCH), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(ret_fire), .wa(e_dest[hidx]), .wd(e_val[hidx]),
    .ra1(disp_src1), .ra2(disp_src2), .rd1(rf1), .rd2(rf2)
  );

  rob_store #(.NE(NUM_ENT), .RW(RW), .DW(DW), .OW(OW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_we(disp_fire), .alloc_idx(tidx), .alloc_op(disp_op), .alloc_dest(disp_dest),
    .a1_ok(op1_ok), .a1_val(op1_val), .a1_tag(rn_tag1),
    .a2_ok(op2_ok), .a2_val(op2_val), .a2_tag(rn_tag2),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
    .iss_we(iss_valid), .iss_idx(pick_idx),
    .ret_we(ret_fire), .ret_idx(hidx),
    .busy(busy), .done(done), .issued(issued), .ok1(ok1), .ok2(ok2),
    .op(e_op), .dest(e_dest), .value(e_val), .v1(e_v1), .v2(e_v2)
  );

  rob_issue_pick #(.NE(NUM_ENT)) u_pick (
    .head(hidx), .cand(cand), .found(pick_found), .pick(pick_idx)
  );

  assign iss_valid = pick_found && !flush;
  assign iss_op    = e_op[pick_idx];
  assign iss_tag   = pick_idx;
  assign iss_a     = e_v1[pick_idx];
  assign iss_b     = e_v2[pick_idx];

  assign ret_valid = ret_fire;
  assign ret_tag   = hidx;
  assign ret_reg   = e_dest[hidx];
  assign ret_value = e_val[hidx];

  generate
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_obs
      assign live_vec[i] = ring_age(i, int'(hidx), NUM_ENT) < int'(occ);
      assign dest_flat[i*RW +: RW] = e_dest[i];
    end
  endgenerate
endmodule

// File: rtl/rob_rename_chk.sv
module rob_rename_chk #(
  parameter int NE = 8,
  parameter int NA = 8,
  localparam int TW = $clog2(NE),
  localparam int RW = $clog2(NA)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic             iss_valid,
  input logic [TW-1:0]    iss_tag,
  input logic             ret_valid,
  input logic [TW-1:0]    ret_tag,
  input logic [NA-1:0]    ren_ok_vec,
  input logic [NA*TW-1:0] ren_tag_flat,
  input logic [NE-1:0]    live_vec,
  input logic [NE*RW-1:0] dest_flat
);
  logic [TW:0]   cnt;
  logic [TW-1:0] exp_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; exp_head <= '0;
    end else if (flush) begin
      cnt <= '0; exp_head <= '0;
    end else begin
      cnt <= cnt + {{TW{1'b0}}, disp_valid && disp_ready} - {{TW{1'b0}}, ret_valid};
      exp_head <= exp_head + {{(TW-1){1'b0}}, ret_valid};
    end
  end

  generate
    for (genvar r = 0; r < NA; r++) begin : g_reg
      logic [TW-1:0] t;
      assign t = ren_tag_flat[r*TW +: TW];
      AST_RENAME_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_ok_vec[r] |-> (live_vec[t] && dest_flat[t*RW +: RW] == RW'(r))); // R3
    end
  endgenerate

  AST_RETIRE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (ret_tag == exp_head && cnt != '0)); // R2
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == (TW+1)'(NE)) |-> !disp_ready); // R6
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (TW+1)'(NE)); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!ret_valid && !iss_valid && (&ren_ok_vec))); // R7
  AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !flush) |=> !(iss_valid && iss_tag == $past(iss_tag))); // R8
endmodule

bind rob_rename rob_rename_chk #(.NE(NUM_ENT), .NA(NUM_ARCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .disp_valid(disp_valid), .disp_ready(disp_ready),
  .iss_valid(iss_valid), .iss_tag(iss_tag),
  .ret_valid(ret_valid), .ret_tag(ret_tag),
  .ren_ok_vec(ren_ok_vec), .ren_tag_flat(ren_tag_flat),
  .live_vec(live_vec), .dest_flat(dest_flat)
);

// File: tb/sim_rob_rename.sv
`timescale 1ns/1ps
module sim_rob_rename;
  localparam int NE = 8, NA = 8, DW = 16, OW = 2, TW = 3, RW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, flush, disp_valid, disp_ready, res_valid;
  logic [OW-1:0] disp_op;
  logic [RW-1:0] disp_src1, disp_src2, disp_dest;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_value;
  logic iss_valid, ret_valid;
  logic [OW-1:0] iss_op;
  logic [TW-1:0] iss_tag, ret_tag;
  logic [DW-1:0] iss_a, iss_b, ret_value;
  logic [RW-1:0] ret_reg;

  rob_rename u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_src1(disp_src1),
    .disp_src2(disp_src2), .disp_dest(disp_dest), .disp_ready(disp_ready),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_tag(iss_tag),
    .iss_a(iss_a), .iss_b(iss_b),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_reg(ret_reg), .ret_value(ret_value)
  );

  int checks = 0, errors = 0;

  // Reference state, indexed by slot
  int s_done[NE], s_iss[NE], s_dep1[NE], s_dep2[NE];
  int e_a[NE], e_b[NE], e_res[NE], e_op[NE], e_dest[NE];
  int spec_rf[NA], com_rf[NA], ren_pend[NA], ren_tag[NA];
  int m_head, m_cnt;
  int pq[$];

  function automatic int alu(int op, int a, int b);
    case (op)
      0: return (a + b) & 16'hFFFF;
      1: return (a - b) & 16'hFFFF;
      2: return (a ^ b) & 16'hFFFF;
      default: return (a & b) & 16'hFFFF;
    endcase
  endfunction

  function automatic int exp_pick();
    for (int k = 0; k < m_cnt; k++) begin
      int t = (m_head + k) % NE;
      if (!s_iss[t] && s_dep1[t] < 0 && s_dep2[t] < 0) return t;
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NE; i++) begin
      s_done[i] = 0; s_iss[i] = 0; s_dep1[i] = -1; s_dep2[i] = -1;
    end
    for (int r = 0; r < NA; r++) begin spec_rf[r] = com_rf[r]; ren_pend[r] = 0; end
    m_head = 0; m_cnt = 0;
    pq.delete();
  endtask

  // One cycle: drive at the falling edge, compare 1 ns later, then advance the model.
  task automatic step(input bit fl, input bit dv, input int op, input int s1,
                      input int s2, input int d, input bit bok);
    bit rdy, er, bc;
    int bt, e, tail;
    @(negedge clk);
    rdy = disp_ready;
    chk(rdy == (m_cnt < NE), "R6 disp_ready", int'(rdy), int'(m_cnt < NE));
    bc = 1'b0; bt = 0;
    if (!fl && bok && pq.size() > 0) begin
      int k = int'($urandom % pq.size());
      bt = pq[k]; pq.delete(k); bc = 1'b1;
    end
    flush = fl; disp_valid = dv;
    disp_op = OW'(op); disp_src1 = RW'(s1); disp_src2 = RW'(s2); disp_dest = RW'(d);
    res_valid = bc; res_tag = TW'(bt); res_value = bc ? DW'(e_res[bt]) : '0;
    #1;
    e  = fl ? -1 : exp_pick();
    er = !fl && m_cnt > 0 && s_done[m_head] != 0;
    chk(iss_valid == (e >= 0), "R8 iss_valid", int'(iss_valid), int'(e >= 0));
    if (iss_valid && e >= 0) begin
      chk(int'(iss_tag) == e, "R8 oldest ready tag", int'(iss_tag), e);
      chk(int'(iss_op) == e_op[e], "R8 iss_op", int'(iss_op), e_op[e]);
      chk(int'(iss_a) == e_a[e], "R3 R4 R5 operand a", int'(iss_a), e_a[e]);
      chk(int'(iss_b) == e_b[e], "R3 R4 R5 operand b", int'(iss_b), e_b[e]);
    end
    chk(ret_valid == er, "R2 ret_valid", int'(ret_valid), int'(er));
    if (ret_valid && er) begin
      chk(int'(ret_tag) == m_head, "R2 ret_tag", int'(ret_tag), m_head);
      chk(int'(ret_reg) == e_dest[m_head], "R2 ret_reg", int'(ret_reg), e_dest[m_head]);
      chk(int'(ret_value) == e_res[m_head], "R2 ret_value", int'(ret_value), e_res[m_head]);
    end
    if (fl) begin
      model_clear(); // R7: dispatch in this cycle is dropped
      return;
    end
    tail = (m_head + m_cnt) % NE;
    if (iss_valid && e >= 0) begin s_iss[e] = 1; pq.push_back(e); end
    if (er) begin
      com_rf[e_dest[m_head]] = e_res[m_head];
      if (ren_pend[e_dest[m_head]] != 0 && ren_tag[e_dest[m_head]] == m_head)
        ren_pend[e_dest[m_head]] = 0;
      s_done[m_head] = 0;
      m_head = (m_head + 1) % NE; m_cnt--;
    end
    if (bc) begin
      s_done[bt] = 1;
      for (int i = 0; i < NE; i++) begin
        if (s_dep1[i] == bt) s_dep1[i] = -1;
        if (s_dep2[i] == bt) s_dep2[i] = -1;
      end
    end
    if (dv && rdy) begin
      e_a[tail] = spec_rf[s1]; e_b[tail] = spec_rf[s2];
      s_dep1[tail] = (ren_pend[s1] != 0 && s_done[ren_tag[s1]] == 0) ? ren_tag[s1] : -1;
      s_dep2[tail] = (ren_pend[s2] != 0 && s_done[ren_tag[s2]] == 0) ? ren_tag[s2] : -1;
      e_op[tail] = op; e_dest[tail] = d;
      e_res[tail] = alu(op, e_a[tail], e_b[tail]);
      s_done[tail] = 0; s_iss[tail] = 0;
      spec_rf[d] = e_res[tail]; ren_pend[d] = 1; ren_tag[d] = tail;
      m_cnt++;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2741));
    rst_n = 1'b0; flush = 1'b0; disp_valid = 1'b0; disp_op = '0;
    disp_src1 = '0; disp_src2 = '0; disp_dest = '0;
    res_valid = 1'b0; res_tag = '0; res_value = '0;
    for (int r = 0; r < NA; r++) com_rf[r] = r;  // R1: register r resets to r
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(disp_ready == 1'b1, "R1 reset disp_ready", int'(disp_ready), 1);
    chk(iss_valid == 1'b0, "R1 reset iss_valid", int'(iss_valid), 0);
    chk(ret_valid == 1'b0, "R1 reset ret_valid", int'(ret_valid), 0);

    // Directed: a dependent chain reading reset values, then filling to full (R6)
    step(0, 1, 0, 1, 2, 3, 0);   // r3 = r1 + r2
    step(0, 1, 1, 3, 3, 4, 0);   // r4 = r3 - r3, waits on tag
    step(0, 1, 2, 4, 5, 3, 0);   // r3 renamed again
    for (int i = 0; i < 8; i++) step(0, 1, i % 4, i % NA, (i + 3) % NA, (i + 5) % NA, 0);
    repeat (40) step(0, 0, 0, 0, 0, 0, 1);

    // Directed: same-cycle bypass and flush with a dispatch in the flush cycle (R7)
    step(0, 1, 0, 6, 7, 6, 0);
    step(0, 1, 0, 6, 6, 7, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 3, 7, 6, 1, 1);
    step(1, 1, 0, 1, 1, 2, 0);
    step(0, 1, 0, 1, 2, 0, 0);   // reads committed file only
    repeat (20) step(0, 0, 0, 0, 0, 0, 1);

    // Constrained random traffic
    for (int c = 0; c < 6000; c++) begin
      bit fl = ($urandom % 64) == 0;
      bit dv = ($urandom % 4) != 0;
      bit bk = ($urandom % 3) != 0;
      step(fl, dv, int'($urandom % 4), int'($urandom % NA), int'($urandom % NA),
           int'($urandom % NA), bk);
    end
    repeat (40) step(0, 0, 0, 0, 0, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule